// File: doc/BRIEF.md
# Color Palette Lookup with True-Color Bypass

This block is the digital front end of a display output stage. A pixel stream comes in one pixel per clock. Each pixel leaves as three component words, red, green and blue, one for each downstream converter channel. In indexed mode the pixel is a logical color number. It reads one entry of a small writable color table, and the entry supplies the three components. In direct (true-color) mode the pixel already carries all three components. They go to the outputs unchanged, and the table is not read.

A host-side write port loads table entries at any time, including while pixels are flowing. Both modes take the same fixed two-clock path from pixel input to output, so the mode can change on any pixel without shifting the alignment of the stream. A blanking input zeroes the three outputs for the pixels it marks, whatever the mode or pixel value.

Top module: `color_map_unit`

## Requirements
- R1: While `rst_n` is low and at the first clock after it is released, `out_vld` is 0 and `out_r`, `out_g`, `out_b` are all zero.
- R2: In indexed mode (`mode_direct` = 0), the outputs equal the table entry selected by `pix_data[7:0]`. The entry word is laid out as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: In direct mode (`mode_direct` = 1), `out_r` = `pix_data[23:16]`, `out_g` = `pix_data[15:8]` and `out_b` = `pix_data[7:0]`, whatever the table holds.
- R4: `out_vld` and the output data appear exactly two clocks after the pixel is presented with `pix_vld` high, in both modes. The mode may change from one pixel to the next without loss or reordering.
- R5: A table write (`tbl_we` high with `tbl_addr`, `tbl_wdata`) is seen by a lookup of that entry presented in the following clock or later.
- R6: If a lookup and a write hit the same entry in the same clock, the lookup returns the entry's value from before the write.
- R7: A pixel presented with `blank` high gives `out_vld` = 1 and all three outputs zero, in either mode.
- R8: In any cycle where `out_vld` is 0, all three outputs are zero.
- R9: In indexed mode, `pix_data[23:8]` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_vld | input | 1 | A pixel is presented this clock |
| pix_data | input | 24 | Pixel: color number in bits 7:0 (indexed) or {R,G,B} (direct) |
| mode_direct | input | 1 | 1 = direct true-color pixel, 0 = indexed pixel |
| blank | input | 1 | Force this pixel's outputs to zero |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry to write |
| tbl_wdata | input | 24 | Entry value {R,G,B} |
| out_vld | output | 1 | Output components valid |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
The hardest case to reach from the ports is a host write that collides with a lookup of the same entry in the same clock. The old value must come out, and the new value must come out for the very next lookup. The bench builds this case by driving a write and an indexed pixel with the same address in one clock, then repeating the lookup in the next clock. It also changes mode and blanking on every pixel of a dense stream, to show that both paths keep the same two-clock alignment.

// File: rtl/cmu_pkg.sv
// Shared definitions for the color map unit.
// Assumes: three output channels ordered red (most significant), green, blue.
package cmu_pkg;
    localparam int CHANNELS = 3;

    typedef enum logic {
        PIX_INDEXED = 1'b0,
        PIX_DIRECT  = 1'b1
    } pix_mode_e;
endpackage

// File: rtl/cmu_table.sv
// Color table: one write port and one registered read port.
// Assumes: a read and a write to the same entry in one clock return the
// stored value from before the write; the write lands at the same edge.
module cmu_table #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Host writes update the array at the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // A lookup registers the entry; the nonblocking read sees the old value on collision.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/cmu_front.sv
// First pipeline stage: holds the pixel attributes while the table read is under way.
// Assumes: synchronous active-low reset; the pixel word is kept for the direct path.
module cmu_front #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             mode_direct,
    input  logic             blank,
    output logic             s1_vld,
    output cmu_pkg::pix_mode_e s1_mode,
    output logic             s1_blank,
    output logic [PIX_W-1:0] s1_pix
);
    import cmu_pkg::*;

    // Capture the control of each pixel alongside its table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_mode  <= PIX_INDEXED;
            s1_blank <= 1'b0;
            s1_pix   <= '0;
        end else begin
            s1_vld   <= pix_vld;
            s1_mode  <= mode_direct ? PIX_DIRECT : PIX_INDEXED;
            s1_blank <= blank;
            s1_pix   <= pix_data;
        end
    end
endmodule

// File: rtl/cmu_outstage.sv
// Second pipeline stage: picks the table word or the direct pixel for each
// channel, applies blanking and zeroes idle cycles.
// Assumes: channel c uses bits [(c+1)*CH_W-1 : c*CH_W] of both source words.
module cmu_outstage #(
    parameter int CH_W = 8,
    parameter int NCH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s1_vld,
    input  cmu_pkg::pix_mode_e  s1_mode,
    input  logic                s1_blank,
    input  logic [NCH*CH_W-1:0] s1_pix,
    input  logic [NCH*CH_W-1:0] tbl_word,
    output logic                out_vld,
    output logic [NCH*CH_W-1:0] out_word
);
    import cmu_pkg::*;

    logic keep;

    // A channel carries data only for a valid, unblanked pixel.
    always_comb begin
        keep = s1_vld && !s1_blank;
    end

    // Valid flag follows the first stage by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= s1_vld;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CH_W-1:0] src;

        // Pick this channel's component from the selected source.
        always_comb begin
            if (s1_mode == PIX_DIRECT) begin
                src = s1_pix[c*CH_W +: CH_W];
            end else begin
                src = tbl_word[c*CH_W +: CH_W];
            end
        end

        // Register the component, zeroed when blanked or idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_word[c*CH_W +: CH_W] <= '0;
            end else begin
                out_word[c*CH_W +: CH_W] <= keep ? src : '0;
            end
        end
    end
endmodule

// File: rtl/color_map_unit.sv
// Color map unit: indexed pixels look up a writable three-component table;
// direct pixels pass through. Both paths are two clocks long.
// Assumes: the color number sits in the low IDX_W bits of the pixel word.
module color_map_unit #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_vld,
    input  logic [3*CH_W-1:0]     pix_data,
    input  logic                  mode_direct,
    input  logic                  blank,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_addr,
    input  logic [3*CH_W-1:0]     tbl_wdata,
    output logic                  out_vld,
    output logic [CH_W-1:0]       out_r,
    output logic [CH_W-1:0]       out_g,
    output logic [CH_W-1:0]       out_b
);
    import cmu_pkg::*;

    localparam int WORD_W = CHANNELS * CH_W;

    logic              rd_en;
    logic [WORD_W-1:0] tbl_word;
    logic              s1_vld;
    pix_mode_e         s1_mode;
    logic              s1_blank;
    logic [WORD_W-1:0] s1_pix;
    logic [WORD_W-1:0] out_word;

    // The table is read only for valid, unblanked indexed pixels.
    always_comb begin
        rd_en = pix_vld && !mode_direct && !blank;
    end

    cmu_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .re    (rd_en),
        .raddr (pix_data[IDX_W-1:0]),
        .rdata (tbl_word)
    );

    cmu_front #(.PIX_W(WORD_W)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_vld     (pix_vld),
        .pix_data    (pix_data),
        .mode_direct (mode_direct),
        .blank       (blank),
        .s1_vld      (s1_vld),
        .s1_mode     (s1_mode),
        .s1_blank    (s1_blank),
        .s1_pix      (s1_pix)
    );

    cmu_outstage #(.CH_W(CH_W), .NCH(CHANNELS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_vld   (s1_vld),
        .s1_mode  (s1_mode),
        .s1_blank (s1_blank),
        .s1_pix   (s1_pix),
        .tbl_word (tbl_word),
        .out_vld  (out_vld),
        .out_word (out_word)
    );

    // Split the output word into the three converter channels.
    always_comb begin
        out_r = out_word[2*CH_W +: CH_W];
        out_g = out_word[1*CH_W +: CH_W];
        out_b = out_word[0*CH_W +: CH_W];
    end
endmodule

// File: rtl/cmu_checker.sv
// Port-level properties of the color map unit, bound to its top.
// Assumes: synchronous active-low reset; a small counter marks when two
// clocks of history since reset exist.
module cmu_checker #(
    parameter int CH_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_vld,
    input logic [3*CH_W-1:0] pix_data,
    input logic              mode_direct,
    input logic              blank,
    input logic              out_vld,
    input logic [CH_W-1:0]   out_r,
    input logic [CH_W-1:0]   out_g,
    input logic [CH_W-1:0]   out_b
);
    logic [1:0] warm;

    // Count clocks since reset up to two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_r == '0 && out_g == '0 && out_b == '0));

    p_vld_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_vld == $past(pix_vld, 2)));

    p_direct_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(pix_vld && mode_direct && !blank, 2))
        |-> ({out_r, out_g, out_b} == $past(pix_data, 2)));

    p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(pix_vld && blank, 2))
        |-> (out_vld && out_r == '0 && out_g == '0 && out_b == '0));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_r == '0 && out_g == '0 && out_b == '0));
endmodule

bind color_map_unit cmu_checker #(.CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_vld     (pix_vld),
    .pix_data    (pix_data),
    .mode_direct (mode_direct),
    .blank       (blank),
    .out_vld     (out_vld),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b)
);

// File: tb/sim_color_map_unit.sv
module sim_color_map_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_vld = 1'b0;
    logic [23:0] pix_data = '0;
    logic        mode_direct = 1'b0;
    logic        blank = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [23:0] tbl_wdata = '0;
    logic        out_vld;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    color_map_unit u0 (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
        .mode_direct(mode_direct), .blank(blank), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .out_vld(out_vld),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // Expected behaviour from the requirements: table mirror and two-clock delay line.
    logic [23:0] shadow [256];
    logic        e1_v, e2_v;
    logic [23:0] e1_rgb, e2_rgb;
    string       cur_tag = "R8";
    string       e1_tag, e2_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            e1_v <= 1'b0; e2_v <= 1'b0; e1_rgb <= '0; e2_rgb <= '0;
            e1_tag <= "R8"; e2_tag <= "R8";
        end else begin
            e1_v   <= pix_vld;
            e1_rgb <= (!pix_vld || blank) ? 24'h0 :
                      (mode_direct ? pix_data : shadow[pix_data[7:0]]);
            e1_tag <= pix_vld ? cur_tag : "R8";
            e2_v <= e1_v; e2_rgb <= e1_rgb; e2_tag <= e1_tag;
        end
        if (tbl_we) shadow[tbl_addr] <= tbl_wdata;
    end

    // Compare outputs with the expected stream away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_vld !== e2_v || {out_r, out_g, out_b} !== e2_rgb) begin
                bad++;
                $display("FAIL %s: got vld=%0b rgb=%06h, expected vld=%0b rgb=%06h",
                         e2_tag, out_vld, {out_r, out_g, out_b}, e2_v, e2_rgb);
            end
        end
    end

    task automatic step(input bit v, input bit md, input bit bl, input logic [23:0] px,
                        input bit we, input logic [7:0] wa, input logic [23:0] wd,
                        input string tag);
        @(negedge clk);
        pix_vld = v; mode_direct = md; blank = bl; pix_data = px;
        tbl_we = we; tbl_addr = wa; tbl_wdata = wd; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 24'h0, 0, 8'h0, 24'h0, "R8");
    endtask

    function automatic logic [23:0] pat(input int i);
        return {8'(i) ^ 8'h5A, 8'(i + 3), ~8'(i)};
    endfunction

    // R1: outputs quiet during reset.
    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_vld !== 1'b0 || {out_r, out_g, out_b} !== 24'h0) begin
            bad++;
            $display("FAIL R1: got vld=%0b rgb=%06h, expected vld=0 rgb=000000",
                     out_vld, {out_r, out_g, out_b});
        end
        rst_n = 1'b1;
    endtask

    // R5: fill the table through the host port.
    task automatic t_load();
        for (int i = 0; i < 256; i++) step(0, 0, 0, 24'h0, 1, 8'(i), pat(i), "R5");
    endtask

    // R2 and R9: indexed stream, with junk in the upper pixel bits.
    task automatic t_indexed();
        for (int i = 0; i < 40; i++) step(1, 0, 0, {16'h0, 8'(i * 7)}, 0, 8'h0, 24'h0, "R2");
        for (int i = 0; i < 20; i++)
            step(1, 0, 0, {8'(i * 13 + 1), 8'hC3 ^ 8'(i), 8'(255 - i)}, 0, 8'h0, 24'h0, "R9");
        idle(3);
    endtask

    // R3: direct stream, table ignored.
    task automatic t_direct();
        for (int i = 0; i < 30; i++)
            step(1, 1, 0, {8'(i * 9), 8'(i * 5 + 2), 8'(200 - i)}, 0, 8'h0, 24'h0, "R3");
        idle(3);
    endtask

    // R4: mode changes on every pixel, with bubbles.
    task automatic t_mix();
        for (int i = 0; i < 48; i++)
            step((i % 5) != 4, i[0], 0, {8'(i * 3), 8'(i * 11), 8'(i)}, 0, 8'h0, 24'h0, "R4");
        idle(3);
    endtask

    // R7: blanking in both modes.
    task automatic t_blank();
        for (int i = 0; i < 16; i++)
            step(1, i[0], i[1], {8'hFF, 8'(i + 100), 8'(i + 1)}, 0, 8'h0, 24'h0, "R7");
        idle(3);
    endtask

    // R5 and R6: collision returns the old entry, the next lookup the new one.
    task automatic t_collision();
        step(1, 0, 0, 24'h000028, 1, 8'h28, 24'hA1B2C3, "R6");
        step(1, 0, 0, 24'h000028, 0, 8'h0, 24'h0, "R5");
        step(0, 0, 0, 24'h0, 1, 8'h11, 24'h0F1E2D, "R5");
        step(1, 0, 0, 24'h000011, 0, 8'h0, 24'h0, "R5");
        step(1, 0, 0, 24'h0000FF, 1, 8'hFF, 24'h123456, "R6");
        step(1, 0, 0, 24'h0000FF, 0, 8'h0, 24'h0, "R5");
        idle(3);
    endtask

    initial begin
        t_reset();
        t_load();
        t_indexed();
        t_direct();
        t_mix();
        t_blank();
        t_collision();
        idle(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule